// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a pair of clocked monostable pulse generators. Each channel holds a down-counter in place of an external timing network. When a qualifying trigger arrives, the counter loads a programmed width of N clock cycles, and the positive output stays high until the count runs out. The complementary output mirrors it. A further qualifying trigger during the pulse reloads the full width, so the pulse can be stretched without limit and the outputs never drop in between.

Each channel has three inputs, and any one of them can fire the channel: a falling-edge input, a rising-edge input and an active-low clear. Each firing edge counts only when the other two inputs are at set levels. The clear overrides everything else. While it is low, the output is forced low at once and triggers are ignored. Releasing the clear can itself fire the channel when the other two inputs allow it. Edges are found by comparing each input with its value on the previous clock. The inputs are assumed to be synchronous to `clk` already.

Top module: `dual_oneshot`

## Requirements
- R1: A high-to-low change of the falling-edge input, while the rising-edge input and the clear are both high, drives the positive output high for exactly N consecutive cycles. The count starts at the first rising clock edge at which the new levels are present.
- R2: A low-to-high change of the rising-edge input, while the falling-edge input is low and the clear is high, gives the same N-cycle pulse.
- R3: A low-to-high change of the clear, while the falling-edge input is low and the rising-edge input is high, gives the same N-cycle pulse.
- R4: No other change between two combinations of the three input levels starts a pulse. This holds for all 64 ordered pairs of combinations.
- R5: While the clear is low, the positive output is low in that same cycle and no trigger is accepted. The remaining count is discarded, so releasing the clear without a valid release trigger leaves the output low.
- R6: A valid trigger while the pulse is active reloads N. The output stays high with no low cycle, and the total high time is the cycles elapsed before the last trigger plus N.
- R7: The negative output is always the complement of the positive output.
- R8: A width setting of 0 is treated as 1.
- R9: While `rst_n` is low, the positive output is low. The input levels present when reset is released do not count as an edge.
- R10: The two channels are independent. Each uses only its own inputs and its own width field, which is bits [c*8 +: 8] of `width_i` for channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fall_trig_i | input | 2 | Falling-edge trigger input, one bit per channel |
| rise_trig_i | input | 2 | Rising-edge trigger input, one bit per channel |
| clr_n_i | input | 2 | Active-low clear per channel; its release can also trigger |
| width_i | input | 16 | Pulse width in cycles, 8 bits per channel |
| pulse_o | output | 2 | Positive pulse output per channel |
| pulse_n_o | output | 2 | Complementary pulse output per channel |

## Verification
The hardest case to reach is a retrigger that lands exactly one cycle after the previous trigger, repeated many times. Such a stream shows whether a reload ever lets the output drop for a cycle. The bench toggles the rising-edge input every cycle, so a reload falls on every other edge. It samples the output on each of these cycles and then checks that the total run length equals the elapsed cycles plus N. Reset release with a release-trigger pattern already on the inputs is the other awkward case. The bench holds that pattern through reset so that a false first edge would show up as a pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // input levels of one channel, sampled each clock
  typedef struct packed {
    logic fall_in;
    logic rise_in;
    logic clr_n;
  } os_levels_t;
endpackage

// File: rtl/oneshot_rst_sync.sv
module oneshot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/oneshot_trig_detect.sv
module oneshot_trig_detect
  import oneshot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  os_levels_t lvl_i,
  output logic       trig_o
);
  os_levels_t prev_q;
  logic       primed_q;
  logic       fall_hit, rise_hit, rel_hit;

  // edge qualification against the previous clock's levels
  always_comb begin
    fall_hit = prev_q.fall_in & ~lvl_i.fall_in & lvl_i.rise_in & lvl_i.clr_n;
    rise_hit = ~prev_q.rise_in & lvl_i.rise_in & ~lvl_i.fall_in & lvl_i.clr_n;
    rel_hit  = ~prev_q.clr_n & lvl_i.clr_n & ~lvl_i.fall_in & lvl_i.rise_in;
    trig_o   = primed_q & (fall_hit | rise_hit | rel_hit);
  end

  // history is not valid until one clock after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clr_n_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_en, busy;

  always_comb begin
    busy     = (cnt_q != '0);
    load_val = (width_i == '0) ? ONE : width_i;
    cnt_en   = trig_i | ~clr_n_i | busy;
    cnt_d    = cnt_q;
    if (!clr_n_i) begin
      cnt_d = '0;
    end else if (trig_i) begin
      cnt_d = load_val;
    end else if (busy) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = busy;

  // R5
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |=> (cnt_q == '0));

  // R6 and R8
  load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && clr_n_i) |=>
      (cnt_q == (($past(width_i) == '0) ? ONE : $past(width_i))));

  // R1
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_i && !trig_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import oneshot_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       fall_trig_i,
  input  logic [NUM_CH-1:0]       rise_trig_i,
  input  logic [NUM_CH-1:0]       clr_n_i,
  input  logic [NUM_CH*CNT_W-1:0] width_i,
  output logic [NUM_CH-1:0]       pulse_o,
  output logic [NUM_CH-1:0]       pulse_n_o
);
  logic              rst_sync_n;
  logic [NUM_CH-1:0] trig_w;
  logic [NUM_CH-1:0] active_w;

  oneshot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    os_levels_t lvl;

    assign lvl.fall_in = fall_trig_i[g];
    assign lvl.rise_in = rise_trig_i[g];
    assign lvl.clr_n   = clr_n_i[g];

    oneshot_trig_detect u_det (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .lvl_i  (lvl),
      .trig_o (trig_w[g])
    );

    oneshot_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .trig_i   (trig_w[g]),
      .clr_n_i  (clr_n_i[g]),
      .width_i  (width_i[g*CNT_W +: CNT_W]),
      .active_o (active_w[g])
    );

    // clear gates the output without waiting for a clock
    assign pulse_o[g]   = active_w[g] & clr_n_i[g];
    assign pulse_n_o[g] = ~pulse_o[g];

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(pulse_o[g]) |-> $past(trig_w[g]));
  end
endmodule

// File: tb/dual_oneshot_tb_top.sv
`timescale 1ns/1ps
module dual_oneshot_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] fall_trig_i, rise_trig_i, clr_n_i;
  logic [15:0] width_i;
  logic [1:0] pulse_o, pulse_n_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dual_oneshot dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_trig_i (fall_trig_i),
    .rise_trig_i (rise_trig_i),
    .clr_n_i     (clr_n_i),
    .width_i     (width_i),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // levels as {fall_in, rise_in, clr_n}
  task automatic drv(input int ch, input logic [2:0] v);
    fall_trig_i[ch] = v[2];
    rise_trig_i[ch] = v[1];
    clr_n_i[ch]     = v[0];
  endtask

  // 1: falling-edge firing, 2: rising-edge firing, 3: clear release, 0: none
  function automatic int fire_kind(input logic [2:0] p, input logic [2:0] n);
    if (p[2] && !n[2] && n[1] && n[0]) return 1;
    if (!p[1] && n[1] && !n[2] && n[0]) return 2;
    if (!p[0] && n[0] && !n[2] && n[1]) return 3;
    return 0;
  endfunction

  // count high samples of a channel over a window of negedges
  task automatic count_high(input int ch, input int win, output int cnt, output bit cpl_ok);
    cnt = 0;
    cpl_ok = 1'b1;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pulse_o[ch]) cnt++;
      if (pulse_n_o[ch] !== ~pulse_o[ch]) cpl_ok = 1'b0;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    bit ok;
    int kind;
    int w;
    string tag;

    // R9: reset with a clear-release pattern already present
    rst_n   = 1'b0;
    width_i = {8'd3, 8'd4};
    drv(0, 3'b011);
    drv(1, 3'b011);
    repeat (4) @(negedge clk);
    chk(pulse_o == 2'b00, "R9 output low in reset", pulse_o, 0);
    chk(pulse_n_o == 2'b11, "R9 complement high in reset", pulse_n_o, 3);
    rst_n = 1'b1;
    count_high(0, 10, cnt, ok);
    chk(cnt == 0, "R9 no false edge at reset release", cnt, 0);

    // R1-R4 sweep over all ordered level pairs, two widths, channel 0
    drv(1, 3'b101);
    for (int wi = 0; wi < 2; wi++) begin
      w = (wi == 0) ? 1 : 4;
      width_i[7:0] = 8'(w);
      for (int p = 0; p < 8; p++) begin
        for (int n = 0; n < 8; n++) begin
          @(negedge clk);
          drv(0, 3'(p));
          repeat (w + 3) @(negedge clk);
          chk(pulse_o[0] == 1'b0, "R4 idle before transition", pulse_o[0], 0);
          drv(0, 3'(n));
          #1;
          if (n[0] == 1'b0)
            chk(pulse_o[0] == 1'b0, "R5 clear forces output low", pulse_o[0], 0);
          count_high(0, w + 3, cnt, ok);
          kind = fire_kind(3'(p), 3'(n));
          case (kind)
            1: tag = "R1 falling-edge trigger width";
            2: tag = "R2 rising-edge trigger width";
            3: tag = "R3 clear-release trigger width";
            default: tag = "R4 non-trigger transition";
          endcase
          chk(cnt == ((kind != 0) ? w : 0), tag, cnt, (kind != 0) ? w : 0);
          chk(ok, "R7 complement output", 0, 1);
        end
      end
      chk(pulse_o[1] == 1'b0, "R10 other channel untouched", pulse_o[1], 0);
    end

    // R6: retrigger every other cycle, width 5
    width_i[7:0] = 8'd5;
    @(negedge clk);
    drv(0, 3'b001);
    repeat (8) @(negedge clk);
    rise_trig_i[0] = 1'b1;
    ok = 1'b1;
    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      if (!pulse_o[0]) ok = 1'b0;
      rise_trig_i[0] = 1'b0;
      @(negedge clk);
      if (!pulse_o[0]) ok = 1'b0;
      rise_trig_i[0] = 1'b1;
    end
    chk(ok, "R6 no drop during retrigger stream", 0, 1);
    count_high(0, 10, cnt, ok);
    chk(cnt + 20 == 25, "R6 stretched total width", cnt + 20, 25);

    // R5: clear in mid-pulse, then release without a valid pattern
    width_i[7:0] = 8'd6;
    @(negedge clk);
    drv(0, 3'b111);
    repeat (8) @(negedge clk);
    fall_trig_i[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(pulse_o[0] == 1'b1, "R1 pulse running before clear", pulse_o[0], 1);
    clr_n_i[0] = 1'b0;
    #1;
    chk(pulse_o[0] == 1'b0, "R5 immediate clear", pulse_o[0], 0);
    chk(pulse_n_o[0] == 1'b1, "R7 complement on clear", pulse_n_o[0], 1);
    @(negedge clk);
    fall_trig_i[0] = 1'b1;
    @(negedge clk);
    clr_n_i[0] = 1'b1;
    count_high(0, 9, cnt, ok);
    chk(cnt == 0, "R5 remaining count discarded", cnt, 0);

    // R8: zero width acts as one
    width_i[7:0] = 8'd0;
    @(negedge clk);
    fall_trig_i[0] = 1'b0;
    count_high(0, 4, cnt, ok);
    chk(cnt == 1, "R8 zero width gives one cycle", cnt, 1);

    // R10: channel 1 fires with its own width while channel 0 idles
    @(negedge clk);
    drv(0, 3'b111);
    drv(1, 3'b111);
    width_i = {8'd3, 8'd7};
    repeat (10) @(negedge clk);
    fall_trig_i[1] = 1'b0;
    count_high(1, 6, cnt, ok);
    chk(cnt == 3, "R10 channel 1 width", cnt, 3);
    chk(pulse_o[0] == 1'b0, "R10 channel 0 stays idle", pulse_o[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule